// File: doc/BRIEF.md
# Piecewise Fractional Clock Divider

This block divides its input clock by a fractional ratio chosen with a 7-bit select code. The code is decoded piecewise into a divisor. Small divisors come in fine steps and large divisors in coarse steps:

- codes 0 to 63 run from 1.0 to 16.75 in steps of 0.25;
- codes 64 to 95 run from 17.0 to 32.5 in steps of 0.5;
- codes 96 to 127 run from 33 to 64 in whole steps.

A quarter-cycle phase accumulator produces fractional ratios. The average spacing of the output enable pulses equals the divisor exactly. Single intervals differ from each other by at most one input cycle.

There are two outputs. The first is a one-cycle enable pulse train, for logic that stays on the input clock. The second is a derived clock that toggles on every enable pulse. The derived clock has a period of twice the divisor, and its duty is as near 50% as the integer intervals allow. A new code takes effect only at a pulse, so no interval is ever cut short. The accumulator restarts from zero whenever the code changes.

Top module: `fracdiv_piecewise`

## Requirements
- R1: While `rst` is high, `tick` and `clk_div` are 0. In the first cycle after `rst` falls, `tick` is 1.
- R2: For a code c below 64, the divisor in quarter cycles is D4 = 4 + c. Any D4 consecutive cycles hold exactly 4 `tick` pulses.
- R3: For a code c from 64 to 95, D4 = 68 + 2·(c−64). Any D4 consecutive cycles hold exactly 4 `tick` pulses.
- R4: For a code c from 96 to 127, D4 = 132 + 4·(c−96). Any D4 consecutive cycles hold exactly 4 `tick` pulses.
- R5: With code 0 in effect, `tick` is 1 on every cycle.
- R6: Under a fixed code, the distance from one `tick` pulse to the next is either floor(D4/4) or ceil(D4/4) cycles.
- R7: `clk_div` changes value in exactly the cycles where `tick` is 1, and holds its value otherwise.
- R8: The design samples `div_code` only in cycles that produce a pulse. A change between pulses leaves the pulse already under way at the old code's interval.
- R9: When a pulse adopts a code that differs from the one in effect, the accumulator restarts from zero. The next pulse then follows after exactly ceil(D4/4) cycles of the new divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 7 | Divisor select code, piecewise decoded |
| tick | output | 1 | One-cycle enable pulse at the divided rate |
| clk_div | output | 1 | Derived clock, toggles on each tick |

## Verification
The hardest case to reach from the ports is a code switch while the accumulator carries a nonzero remainder. Only then does a missing restart change the first interval under the new code. The remainder is not visible at the ports.

To reach that case, the stimulus first switches to divisor 1.25. That switch clears the accumulator at a known pulse, and from there the remainders cycle through 3, 2, 1 and 0 on successive pulses. The stimulus then requests divisor 17.5 after a staggered number of pulses, so that every remainder meets the switch once. In each run the bench requires the first new interval to be 18 cycles.

// File: rtl/fracdiv_piecewise.sv
module fracdiv_piecewise (
  input  logic       clk,
  input  logic       rst,
  input  logic [6:0] div_code,
  output logic       tick,
  output logic       clk_div
);
  localparam int CW = 7;
  localparam int QW = 9;
  localparam int GW = 7;

  logic [CW-1:0] cur;
  logic [QW-1:0] acc;
  logic [QW-1:0] d4;
  logic [QW:0]   sum;
  logic          hit;
  logic [GW-1:0] since;

  function automatic logic [QW-1:0] quarter_div(input logic [CW-1:0] c);
    if (!c[6])      return 9'd4   + {2'b00, c};
    else if (!c[5]) return 9'd68  + {3'b000, c[4:0], 1'b0};
    else            return 9'd132 + {2'b00, c[4:0], 2'b00};
  endfunction

  assign d4  = quarter_div(cur);
  assign sum = {1'b0, acc} + 10'd4;
  assign hit = sum >= {1'b0, d4};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= '0;
      acc     <= '0;
      tick    <= 1'b0;
      clk_div <= 1'b0;
      since   <= '0;
    end else begin
      tick    <= hit;
      clk_div <= clk_div ^ hit;
      since   <= hit ? '0 : since + 1'b1;
      if (hit) begin
        cur <= div_code;
        acc <= (div_code != cur) ? '0 : QW'(sum - {1'b0, d4});
      end else begin
        acc <= sum[QW-1:0];
      end
    end
  end

  logic [QW:0] lim_up, lim_dn, gap_len;
  assign lim_up  = ({1'b0, d4} + 10'd3) >> 2;
  assign lim_dn  = {1'b0, d4} >> 2;
  assign gap_len = {3'b000, since} + 10'd1;

  AST_GAP_MAX: assert property (@(posedge clk) disable iff (rst) gap_len <= lim_up); // R6
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst) hit |-> gap_len >= lim_dn); // R6
  AST_DIV1_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst) (cur == '0) |=> tick); // R5
  AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (rst) tick |-> (clk_div != $past(clk_div))); // R7
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst) !tick |-> $stable(clk_div)); // R7
  AST_CODE_AT_PULSE: assert property (@(posedge clk) disable iff (rst) !tick |-> $stable(cur)); // R8
  AST_CLEAR_ON_SWITCH: assert property (@(posedge clk) disable iff (rst) (tick && cur != $past(cur)) |-> acc == '0); // R9
  AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (rst) acc < d4); // R2
endmodule

// File: tb/fracdiv_piecewise_test.sv
module fracdiv_piecewise_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] div_code = 7'd0;
  logic       tick;
  logic       clk_div;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  fracdiv_piecewise uut (
    .clk(clk), .rst(rst), .div_code(div_code), .tick(tick), .clk_div(clk_div)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int quarters(int c);
    if (c < 64) return 4 + c;
    else if (c < 96) return 68 + 2 * (c - 64);
    else return 132 + 4 * (c - 96);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 400; i++) begin
      cyc();
      if (tick) return;
    end
  endtask

  task automatic adopt(int c);
    div_code = 7'(c);
    wait_tick();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 4; i++) cyc();
    chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    chk(clk_div == 1'b0, "R1 clk_div in reset", int'(clk_div), 0);
    rst = 1'b0;
    cyc();
    chk(tick == 1'b1, "R1 first pulse after reset", int'(tick), 1);
  endtask

  task automatic t_ratio(int c, string req);
    int d = quarters(c);
    int n1 = 0;
    int n4 = 0;
    int gap = 0;
    int seen = 0;
    bit bad = 0;
    adopt(c);
    for (int i = 0; i < 4 * d; i++) begin
      cyc();
      gap++;
      if (tick) begin
        if (i < d) n1++;
        n4++;
        if (seen > 0 && (gap < d / 4 || gap > (d + 3) / 4)) bad = 1;
        seen++;
        gap = 0;
      end
    end
    chk(n1 == 4, req, n1, 4);
    chk(n4 == 16, req, n4, 16);
    chk(!bad, "R6 pulse spacing", int'(bad), 0);
  endtask

  task automatic t_div1();
    int n = 0;
    adopt(0);
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (tick) n++;
    end
    chk(n == 20, "R5 divide by one", n, 20);
  endtask

  task automatic t_clock();
    logic prev;
    int bad = 0;
    adopt(3);
    prev = clk_div;
    for (int i = 0; i < 60; i++) begin
      cyc();
      if ((clk_div != prev) != tick) bad++;
      prev = clk_div;
    end
    chk(bad == 0, "R7 clk_div toggles with tick", bad, 0);
  endtask

  task automatic t_hold();
    int k = 0;
    int n = 0;
    adopt(127);
    wait_tick();
    for (int i = 0; i < 10; i++) cyc();
    div_code = 7'd0;
    k = 10;
    for (int i = 0; i < 200; i++) begin
      cyc();
      k++;
      if (tick) break;
    end
    chk(k == 64, "R8 interval kept after mid-period change", k, 64);
    for (int i = 0; i < 5; i++) begin
      cyc();
      if (tick) n++;
    end
    chk(n == 5, "R8 new code in effect after pulse", n, 5);
  endtask

  task automatic t_clear();
    for (int j = 0; j < 4; j++) begin
      int k = 0;
      adopt(1);
      for (int t = 0; t < j; t++) wait_tick();
      div_code = 7'd65;
      wait_tick();
      for (int i = 0; i < 100; i++) begin
        cyc();
        k++;
        if (tick) break;
      end
      chk(k == 18, "R9 first interval after switch", k, 18);
    end
  endtask

  initial begin
    t_reset();
    t_ratio(0, "R2 code 0");
    t_ratio(1, "R2 code 1");
    t_ratio(5, "R2 code 5");
    t_ratio(63, "R2 code 63");
    t_ratio(64, "R3 code 64");
    t_ratio(77, "R3 code 77");
    t_ratio(95, "R3 code 95");
    t_ratio(96, "R4 code 96");
    t_ratio(110, "R4 code 110");
    t_ratio(127, "R4 code 127");
    t_div1();
    t_clock();
    t_hold();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule